// File: doc/BRIEF.md
# Calendar Clock Register File

This block keeps time of day and calendar date in a small byte-addressed register file. Software reaches it through a two-address port. Writing the even address selects a register, and the odd address then reads or writes that register. The stored time is seconds, minutes, hours, day of week, day of month, month, two-digit year and century. An internal divider, counting the system clock, produces a once-per-second update strobe. On each strobe the calendar advances, and the strobe is also exported.

Two control bits choose how the time fields appear on the bus. One picks BCD or plain binary. The other picks 24-hour or 12-hour hours, where the 12-hour form carries a PM flag. The time is held internally in binary, so either mode can be selected at any moment without rewriting the fields.

A freeze bit stops counting so that software can load a new time. Certain divider codes also stop the clock. One of these codes holds the divider in reset, and releasing it puts the first update half a second later.

Top module: `calclk_top`

## Requirements
- R1: A write to the even address (`addr_odd`=0) loads bits 6:0 of the data as the register index. A read of the even address returns 0xFF.
- R2: The register indices are: 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 control A, 9 control B, 10 control C, 11 control D. After reset, A reads 0x26, B reads 0x02, C reads 0x00 and D reads 0x80. Reads are registered and appear on `rdata` one cycle after `rd_en`.
- R3: Bit 7 of control A is the update-in-progress flag. Writes to it are ignored. It reads 0 whenever the clock is not running.
- R4: Control B bit 2 set presents and accepts time fields as binary. When it is clear, fields are BCD with the tens digit in bits 7:4.
- R5: Control B bit 1 set selects 24-hour hours. When it is clear, hours read 1 to 12 with bit 7 marking PM, and midnight reads as 12 AM. A write in 12-hour form is converted the same way.
- R6: While control B bit 7 (freeze) is 1, the time fields do not advance, and values written to them are kept.
- R7: A write to control B with bit 7 set stores bit 4 (update interrupt enable) as 0.
- R8: The clock runs only when freeze is 0 and control A bits 6:4 are at most 0b010. While running, `sec_pulse` is high for one cycle every TICKS_PER_SEC cycles, and the time advances by one second on that pulse.
- R9: Control A bits 6:5 both 1 hold the divider in reset with no pulses. After release, the first pulse comes TICKS_PER_SEC/2 cycles later.
- R10: Seconds and minutes wrap after 59 and carry onward. Hours wrap after 23 and carry into the date. Day of week runs 1 to 7 and returns to 1.
- R11: Day of month wraps by month length, with leap years every fourth year except on a century whose number is not a multiple of 4. Month 12 wraps to 1 and carries into the year. Year 99 wraps to 0 and carries into the century.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_odd | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| sec_pulse | output | 1 | One-cycle update strobe, once per second while running |

## Verification
Time values are loaded while frozen. They are then read back under all four combinations of the binary and 12-hour bits, so a wrong nibble split, a bad PM flag or a bad midnight mapping each show up as a distinct byte. Single-update runs start from end-of-day, end-of-year and end-of-February values in leap, non-leap and century years, which separates the day, month, year and century carry paths from one another. The pulse timing after divider release is counted cycle by cycle, and so is the pulse spacing after that, so a full-second first delay can be told apart from the half-second one. Frozen and stopped-divider windows show that no stray update occurs.

// File: rtl/calclk_pkg.sv
package calclk_pkg;

  localparam int FIELDS = 8;

  // Binary time of day and date; seconds occupy the low byte.
  typedef struct packed {
    logic [7:0] cen;
    logic [7:0] yr;
    logic [7:0] mon;
    logic [7:0] dom;
    logic [7:0] dow;
    logic [7:0] hr;
    logic [7:0] min;
    logic [7:0] sec;
  } tod_t;

  function automatic logic [7:0] to_ext(input logic [7:0] v, input logic bin);
    logic [7:0] tens, ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return bin ? v : {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [7:0] from_ext(input logic [7:0] v, input logic bin);
    return bin ? v : (8'(v[7:4]) * 8'd10) + 8'(v[3:0]);
  endfunction

  function automatic logic [7:0] hour_out(input logic [7:0] h, input logic bin,
                                          input logic h24);
    logic [7:0] h12;
    if (h24) return to_ext(h, bin);
    h12 = ((h % 8'd12) == 8'd0) ? 8'd12 : (h % 8'd12);
    return to_ext(h12, bin) | {(h >= 8'd12), 7'b0};
  endfunction

  function automatic logic [7:0] hour_in(input logic [7:0] v, input logic bin,
                                         input logic h24);
    logic [7:0] t;
    if (h24) return from_ext(v, bin);
    t = from_ext({1'b0, v[6:0]}, bin);
    return (t % 8'd12) + (v[7] ? 8'd12 : 8'd0);
  endfunction

  function automatic logic is_leap(input logic [7:0] yr, input logic [7:0] cen);
    return (yr[1:0] == 2'b00) && ((yr != 8'd0) || (cen[1:0] == 2'b00));
  endfunction

  function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr,
                                           input logic [7:0] cen);
    case (mon)
      8'd2:                      return is_leap(yr, cen) ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
      default:                   return 8'd31;
    endcase
  endfunction

  function automatic tod_t advance(input tod_t t);
    tod_t n;
    n = t;
    if (t.sec < 8'd59) n.sec = t.sec + 8'd1;
    else begin
      n.sec = 8'd0;
      if (t.min < 8'd59) n.min = t.min + 8'd1;
      else begin
        n.min = 8'd0;
        if (t.hr < 8'd23) n.hr = t.hr + 8'd1;
        else begin
          n.hr  = 8'd0;
          n.dow = (t.dow >= 8'd7) ? 8'd1 : t.dow + 8'd1;
          if (t.dom < month_len(t.mon, t.yr, t.cen)) n.dom = t.dom + 8'd1;
          else begin
            n.dom = 8'd1;
            if (t.mon < 8'd12) n.mon = t.mon + 8'd1;
            else begin
              n.mon = 8'd1;
              if (t.yr < 8'd99) n.yr = t.yr + 8'd1;
              else begin
                n.yr  = 8'd0;
                n.cen = (t.cen < 8'd99) ? t.cen + 8'd1 : 8'd0;
              end
            end
          end
        end
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/calclk_divider.sv
module calclk_divider #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic run,
  output logic tick,
  output logic uip
);
  localparam int CW       = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
  localparam int LAST     = TICKS_PER_SEC - 1;
  localparam int HALF     = TICKS_PER_SEC / 2;
  localparam int UIP_FROM = TICKS_PER_SEC - UIP_TICKS;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt <= '0;
    else if (hold)               cnt <= CW'(HALF);
    else if (cnt == CW'(LAST))   cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == CW'(LAST));
  assign uip  = run && (cnt >= CW'(UIP_FROM));
endmodule

// File: rtl/calclk_timekeeper.sv
module calclk_timekeeper
  import calclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic       fld_we,
  input  logic [2:0] fld_sel,
  input  logic [7:0] fld_val,
  output tod_t       tod
);
  tod_t nxt;

  always_comb begin
    nxt = step ? advance(tod) : tod;
    if (fld_we) nxt[fld_sel*8 +: 8] = fld_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tod <= '{cen: 8'd20, yr: 8'd0, mon: 8'd1, dom: 8'd1, dow: 8'd7,
                         hr: 8'd0, min: 8'd0, sec: 8'd0};
    else        tod <= nxt;
  end
endmodule

// File: rtl/calclk_hostport.sv
module calclk_hostport
  import calclk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_odd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  input  tod_t       tod,
  input  logic       uip,
  output logic [7:0] rdata,
  output logic [6:0] ctl_a,
  output logic [7:0] ctl_b,
  output logic       fld_we,
  output logic [2:0] fld_sel,
  output logic [7:0] fld_val
);
  localparam logic [6:0] IDX_A = 7'd8;
  localparam logic [6:0] IDX_B = 7'd9;
  localparam logic [6:0] IDX_C = 7'd10;
  localparam logic [6:0] IDX_D = 7'd11;

  logic [6:0] idx;
  logic [7:0] rd_mux;
  logic       bin, h24, data_wr;

  assign bin     = ctl_b[2];
  assign h24     = ctl_b[1];
  assign data_wr = wr_en && addr_odd;
  assign fld_we  = data_wr && (idx < 7'(FIELDS));
  assign fld_sel = idx[2:0];
  assign fld_val = (idx == 7'd2) ? hour_in(wdata, bin, h24) : from_ext(wdata, bin);

  always_comb begin
    if (!addr_odd)                rd_mux = 8'hFF;
    else if (idx == 7'd2)         rd_mux = hour_out(tod.hr, bin, h24);
    else if (idx < 7'(FIELDS))    rd_mux = to_ext(tod[idx[2:0]*8 +: 8], bin);
    else begin
      case (idx)
        IDX_A:   rd_mux = {uip, ctl_a};
        IDX_B:   rd_mux = ctl_b;
        IDX_C:   rd_mux = 8'h00;
        IDX_D:   rd_mux = 8'h80;
        default: rd_mux = 8'h00;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx   <= '0;
      ctl_a <= 7'h26;
      ctl_b <= 8'h02;
      rdata <= 8'h00;
    end else begin
      if (wr_en && !addr_odd) idx <= wdata[6:0];
      if (data_wr && idx == IDX_A) ctl_a <= wdata[6:0];
      if (data_wr && idx == IDX_B) ctl_b <= wdata[7] ? (wdata & 8'hEF) : wdata;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/calclk_top.sv
module calclk_top
  import calclk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 32768,
  parameter int UIP_TICKS     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       addr_odd,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       sec_pulse
);
  tod_t       tod;
  logic [6:0] ctl_a;
  logic [7:0] ctl_b;
  logic       fld_we, uip, running, div_hold;
  logic [2:0] fld_sel;
  logic [7:0] fld_val;

  assign div_hold = &ctl_a[6:5];
  assign running  = !ctl_b[7] && (ctl_a[6:4] <= 3'b010);

  calclk_divider #(.TICKS_PER_SEC(TICKS_PER_SEC), .UIP_TICKS(UIP_TICKS)) u_div (
    .clk(clk), .rst_n(rst_n), .hold(div_hold), .run(running),
    .tick(sec_pulse), .uip(uip)
  );

  calclk_timekeeper u_tk (
    .clk(clk), .rst_n(rst_n), .step(sec_pulse), .fld_we(fld_we),
    .fld_sel(fld_sel), .fld_val(fld_val), .tod(tod)
  );

  calclk_hostport u_hp (
    .clk(clk), .rst_n(rst_n), .addr_odd(addr_odd), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .tod(tod), .uip(uip), .rdata(rdata), .ctl_a(ctl_a),
    .ctl_b(ctl_b), .fld_we(fld_we), .fld_sel(fld_sel), .fld_val(fld_val)
  );
endmodule

// File: rtl/calclk_chk.sv
module calclk_chk
  import calclk_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       addr_odd,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       sec_pulse,
  input logic [6:0] ctl_a,
  input logic [7:0] ctl_b,
  input tod_t       tod,
  input logic       fld_we,
  input logic       uip,
  input logic       running,
  input logic       div_hold
);
  AST_EVEN_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !addr_odd |=> rdata == 8'hFF); // R1
  AST_UIP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !uip); // R3
  AST_FROZEN_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[7] && !fld_we |=> $stable(tod)); // R6
  AST_UIE_OFF_WHEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_b[7] |-> !ctl_b[4]); // R7
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse); // R8
  AST_PULSE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |-> ctl_a[6:4] <= 3'b010 && !ctl_b[7]); // R8
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    div_hold |-> !sec_pulse); // R9
  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !fld_we && tod.sec < 8'd59 |=> tod.sec == $past(tod.sec) + 8'd1); // R10
endmodule

bind calclk_top calclk_chk u_chk (.*);

// File: tb/sim_calclk_top.sv
module sim_calclk_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_odd = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sec_pulse;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic rd_seen = 1'b0;

  always #10 clk = ~clk;

  calclk_top #(.TICKS_PER_SEC(16), .UIP_TICKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_odd(addr_odd), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sec_pulse(sec_pulse)
  );

  // monitor: compare each registered read against the scoreboard
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_run++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", t, rdata, e);
      end
    end
  end

  task automatic check_val(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic odd, input logic [7:0] d);
    @(negedge clk);
    addr_odd = odd; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [6:0] idx, input logic [7:0] d);
    bus_wr(1'b0, {1'b0, idx});
    bus_wr(1'b1, d);
  endtask

  task automatic even_rd(input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr_odd = 1'b0; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [6:0] idx, input logic [7:0] exp, input string tag);
    bus_wr(1'b0, {1'b0, idx});
    @(negedge clk);
    addr_odd = 1'b1; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // load a BCD 24-hour time while frozen
  task automatic load_time(input logic [7:0] s, m, h, dw, dm, mo, y, c);
    reg_wr(7'd9, 8'h82);
    reg_wr(7'd0, s);  reg_wr(7'd1, m);  reg_wr(7'd2, h);  reg_wr(7'd3, dw);
    reg_wr(7'd4, dm); reg_wr(7'd5, mo); reg_wr(7'd6, y);  reg_wr(7'd7, c);
  endtask

  // hold divider, unfreeze, release and watch pulses for ncyc cycles, then refreeze
  task automatic run_window(input int ncyc, output int np, output int first, output int last);
    np = 0; first = -1; last = -1;
    reg_wr(7'd8, 8'h70);
    reg_wr(7'd9, 8'h02);
    reg_wr(7'd8, 8'h26);
    for (int k = 1; k <= ncyc; k++) begin
      @(negedge clk);
      if (sec_pulse) begin
        np++;
        if (first < 0) first = k;
        last = k;
      end
    end
    reg_wr(7'd9, 8'h82);
  endtask

  task automatic read_date(input logic [7:0] s, m, h, dw, dm, mo, y, c, input string tag);
    reg_rd(7'd0, s, tag);  reg_rd(7'd1, m, tag);  reg_rd(7'd2, h, tag);
    reg_rd(7'd3, dw, tag); reg_rd(7'd4, dm, tag); reg_rd(7'd5, mo, tag);
    reg_rd(7'd6, y, tag);  reg_rd(7'd7, c, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int np, f, l;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset values (A read under freeze so UIP is 0)
    reg_rd(7'd9,  8'h02, "R2 ctlB reset");
    reg_rd(7'd10, 8'h00, "R2 ctlC reset");
    reg_rd(7'd11, 8'h80, "R2 ctlD reset");
    reg_wr(7'd9, 8'h82);
    reg_rd(7'd8,  8'h26, "R2 ctlA reset");

    // R1 even port reads 0xFF
    even_rd(8'hFF, "R1 even read");

    // R3 UIP bit write ignored
    reg_wr(7'd8, 8'hA6);
    reg_rd(7'd8, 8'h26, "R3 UIP read-only");

    // R7 freeze clears update interrupt enable
    reg_wr(7'd9, 8'h92);
    reg_rd(7'd9, 8'h82, "R7 UIE forced low");

    // R4/R5 encodings
    load_time(8'h45, 8'h30, 8'h13, 8'h03, 8'h15, 8'h06, 8'h24, 8'h20);
    reg_rd(7'd0, 8'h45, "R4 BCD seconds");
    reg_wr(7'd9, 8'h86);
    reg_rd(7'd0, 8'h2D, "R4 binary seconds");
    reg_rd(7'd2, 8'h0D, "R4 binary hours 24h");
    reg_wr(7'd9, 8'h84);
    reg_rd(7'd2, 8'h81, "R5 binary 12h PM");
    reg_wr(7'd9, 8'h80);
    reg_rd(7'd2, 8'h81, "R5 BCD 12h 1 PM");
    reg_wr(7'd2, 8'h12);
    reg_wr(7'd9, 8'h82);
    reg_rd(7'd2, 8'h00, "R5 12 AM is midnight");
    reg_wr(7'd9, 8'h80);
    reg_rd(7'd2, 8'h12, "R5 midnight shows 12");
    reg_wr(7'd2, 8'h92);
    reg_wr(7'd9, 8'h82);
    reg_rd(7'd2, 8'h12, "R5 12 PM is noon");

    // R6 freeze holds written fields
    reg_wr(7'd0, 8'h07);
    repeat (40) @(negedge clk);
    reg_rd(7'd0, 8'h07, "R6 frozen seconds held");

    // R9 half-second first update, R8 full-second spacing
    run_window(30, np, f, l);
    check_val("R9 first pulse delay", f, 7);
    check_val("R8 pulse count", np, 2);
    check_val("R8 pulse spacing", l - f, 16);
    reg_rd(7'd0, 8'h09, "R8 two seconds advanced");

    // R9 divider reset holds
    reg_wr(7'd8, 8'h70);
    reg_wr(7'd9, 8'h02);
    np = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sec_pulse) np++; end
    check_val("R9 no pulse in divider reset", np, 0);
    // R8 non-running divider code
    reg_wr(7'd8, 8'h50);
    np = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sec_pulse) np++; end
    check_val("R8 no pulse for stopped code", np, 0);
    reg_rd(7'd8, 8'h50, "R3 UIP low when stopped");
    reg_rd(7'd0, 8'h09, "R8 seconds unchanged when stopped");
    reg_wr(7'd8, 8'h26);

    // R10/R11 end of year and century
    load_time(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99, 8'h19);
    run_window(12, np, f, l);
    check_val("R10 single update", np, 1);
    read_date(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h20, "R11 year/century carry");

    // R11 leap century year 2000
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h20);
    run_window(12, np, f, l);
    read_date(8'h00, 8'h00, 8'h00, 8'h03, 8'h29, 8'h02, 8'h00, 8'h20, "R11 leap 2000");

    // R11 non-leap century year 2100
    load_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h28, 8'h02, 8'h00, 8'h21);
    run_window(12, np, f, l);
    read_date(8'h00, 8'h00, 8'h00, 8'h03, 8'h01, 8'h03, 8'h00, 8'h21, "R11 no leap 2100");

    // R11 non-leap 2023, and 30-day month
    load_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23, 8'h20);
    run_window(12, np, f, l);
    read_date(8'h00, 8'h00, 8'h00, 8'h04, 8'h01, 8'h03, 8'h23, 8'h20, "R11 no leap 2023");
    load_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h30, 8'h04, 8'h24, 8'h20);
    run_window(12, np, f, l);
    read_date(8'h00, 8'h00, 8'h00, 8'h06, 8'h01, 8'h05, 8'h24, 8'h20, "R11 30-day month");

    // R10 minute carry without hour carry
    load_time(8'h59, 8'h59, 8'h10, 8'h02, 8'h10, 8'h08, 8'h24, 8'h20);
    run_window(12, np, f, l);
    read_date(8'h00, 8'h00, 8'h11, 8'h02, 8'h10, 8'h08, 8'h24, 8'h20, "R10 hour carry");

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule